// File: doc/BRIEF.md
# Battery Pack Fault Supervisor

This block is the digital supervisor of a protector for a pack of three or four lithium cells. The analog front end has already turned its comparators into logic flags, and those flags reach the block synchronised to its clock. Four of them report current faults: overcurrent while charging, overload while discharging, and a short circuit in either direction. Two report the supply: brownout and shutdown. The block also takes a one-clock tick at the 32.768 kHz timing rate, the level of the external control pin, and the host's control byte and delay codes as parallel ports.

Each current fault must persist for a programmable number of ticks before it counts. A qualified fault latches into a status bit, turns off the charge and discharge gate enables, and pulls an active-low alert low. The latch holds until the host raises control bit 0 and then lowers it. If the condition is still present after that, it qualifies again from scratch. Brownout and shutdown are reported through two further status bits, each with its own clearing rule.

Top module: `pack_guard`

## Requirements
- R1: After reset, status is all zero, alert_n is 1, chg_en and dsg_en are 0, and pchg_en is 1 while ctl_pin is low.
- R2: The charge-overcurrent flag qualifies after 33*(2*oc_code+1) ticks and the discharge-overload flag after 33*(2*ol_code+1) ticks. Each uses its own code, giving 1 ms to 31 ms in 2 ms steps.
- R3: Either short-circuit flag qualifies after 2*sc_code ticks. With sc_code 0 the fault latches on the first clock edge that sees the flag.
- R4: A fault flag that drops before it qualifies restarts its count from zero.
- R5: A qualified fault sets its status bit and holds chg_en and dsg_en at 0 while any such bit is set. The bits are: status[0] charge overcurrent, status[1] discharge overload, status[2] short circuit while charging, status[3] short circuit while discharging. Any set bit drives alert_n low.
- R6: Current-fault bits stay set until ctrl_reg[0] goes 1 and then 0. They clear on the clock edge that sees the 0. If the flag persists, the fault qualifies again after its full delay.
- R7: ctrl_reg[1]=1 requests dsg_en and ctrl_reg[2]=1 requests chg_en. A request has effect only when no current fault is latched, ctl_pin is low and status[5] is 0.
- R8: pchg_en is 1 unless ctrl_reg[3]=1, ctl_pin is high or status[5] is set.
- R9: ctl_pin high forces chg_en, dsg_en and pchg_en to 0.
- R10: While precharge is in progress, current-fault counting is held at zero and no current fault latches. Precharge is in progress when pchg_en is 1 and both chg_en and dsg_en are 0.
- R11: bro_flag sets status[4] and drives alert_n low. A stat_rd pulse releases that alert. status[4] clears only on the first stat_rd that follows a complete ctrl_reg[0] pulse.
- R12: status[5] follows sd_flag one clock later. While status[5] is set, all three gate enables are 0 and the shutdown alone does not pull alert_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-clock pulse at the 32.768 kHz timing rate |
| oc_chg_flag | input | 1 | Charge overcurrent comparator |
| ol_dsg_flag | input | 1 | Discharge overload comparator |
| sc_chg_flag | input | 1 | Short-circuit comparator, charge direction |
| sc_dsg_flag | input | 1 | Short-circuit comparator, discharge direction |
| bro_flag | input | 1 | Brownout comparator |
| sd_flag | input | 1 | Shutdown comparator |
| ctl_pin | input | 1 | External control level; high forces all gates off |
| ctrl_reg | input | 4 | Host control: [0] clear, [1] discharge on, [2] charge on, [3] precharge off |
| oc_code | input | 4 | Charge overcurrent delay code |
| ol_code | input | 4 | Discharge overload delay code |
| sc_code | input | 4 | Short-circuit delay code |
| stat_rd | input | 1 | One-clock pulse marking a host read of status |
| chg_en | output | 1 | Charge gate enable |
| dsg_en | output | 1 | Discharge gate enable |
| pchg_en | output | 1 | Precharge gate enable |
| alert_n | output | 1 | Active-low alert |
| status | output | 6 | Fault and supply status bits |

## Verification
The hardest state to reach is re-qualification after a clear. The fault must still be present, and precharge gating keeps its counter at zero for the whole time the fault is latched. The clear pulse therefore has to be given with the main gates still requested. Only then does the tick count restart and reach the limit again exactly. The stimulus holds the flag high through the clear and counts ticks up to one below the limit and then to the limit. A second sequence turns precharge off with all gates idle, to show that counting resumes when the gating condition lifts.

// File: rtl/pack_guard.sv
module pack_guard #(
  parameter int CODE_W            = 4,
  parameter int TICKS_PER_MS      = 33,
  parameter int SC_TICKS_PER_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              oc_chg_flag,
  input  logic              ol_dsg_flag,
  input  logic              sc_chg_flag,
  input  logic              sc_dsg_flag,
  input  logic              bro_flag,
  input  logic              sd_flag,
  input  logic              ctl_pin,
  input  logic [3:0]        ctrl_reg,
  input  logic [CODE_W-1:0] oc_code,
  input  logic [CODE_W-1:0] ol_code,
  input  logic [CODE_W-1:0] sc_code,
  input  logic              stat_rd,
  output logic              chg_en,
  output logic              dsg_en,
  output logic              pchg_en,
  output logic              alert_n,
  output logic [5:0]        status
);

  localparam int NF     = 4;
  localparam int LONG_MAX = TICKS_PER_MS * (2 * (2**CODE_W - 1) + 1);
  localparam int SC_MAX = SC_TICKS_PER_STEP * (2**CODE_W - 1);
  localparam int TOP    = (LONG_MAX > SC_MAX) ? LONG_MAX : SC_MAX;
  localparam int CNT_W  = $clog2(TOP + 1);

  function automatic logic [CNT_W-1:0] long_lim(input logic [CODE_W-1:0] c);
    int v;
    v = TICKS_PER_MS * (2 * int'(c) + 1);
    return CNT_W'(v);
  endfunction

  function automatic logic [CNT_W-1:0] short_lim(input logic [CODE_W-1:0] c);
    int v;
    v = SC_TICKS_PER_STEP * int'(c);
    return CNT_W'(v);
  endfunction

  logic [NF-1:0]    flag, hit, fault_q;
  logic [CNT_W-1:0] lim [NF];
  logic             sd_q, bro_q, bro_arm, bro_alert, ctrl0_q;
  logic             clr_pulse, bro_clr, trip, force_off, prechg;

  assign flag   = {sc_dsg_flag, sc_chg_flag, ol_dsg_flag, oc_chg_flag};
  assign lim[0] = long_lim(oc_code);
  assign lim[1] = long_lim(ol_code);
  assign lim[2] = short_lim(sc_code);
  assign lim[3] = short_lim(sc_code);

  assign trip      = |fault_q;
  assign force_off = ctl_pin | sd_q;
  assign dsg_en    = ~force_off & ~trip & ctrl_reg[1];
  assign chg_en    = ~force_off & ~trip & ctrl_reg[2];
  assign pchg_en   = ~force_off & ~ctrl_reg[3];
  assign prechg    = pchg_en & ~chg_en & ~dsg_en;

  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_qual
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!flag[i] || prechg) cnt <= '0;
        else if (tick_in && cnt < lim[i]) cnt <= cnt + CNT_W'(1);
      end
      assign hit[i] = flag[i] & ~prechg & (cnt >= lim[i]);
    end
  endgenerate

  assign clr_pulse = ctrl0_q & ~ctrl_reg[0];
  assign bro_clr   = stat_rd & bro_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q   <= '0;
      ctrl0_q   <= 1'b0;
      sd_q      <= 1'b0;
      bro_q     <= 1'b0;
      bro_arm   <= 1'b0;
      bro_alert <= 1'b0;
    end else begin
      ctrl0_q <= ctrl_reg[0];
      sd_q    <= sd_flag;
      if (clr_pulse) fault_q <= '0;
      else           fault_q <= fault_q | hit;

      if (bro_clr)       bro_q <= 1'b0;
      else if (bro_flag) bro_q <= 1'b1;

      if (bro_clr)                 bro_arm <= 1'b0;
      else if (clr_pulse && bro_q) bro_arm <= 1'b1;

      if (bro_flag && !bro_q && !bro_clr) bro_alert <= 1'b1;
      else if (stat_rd)                   bro_alert <= 1'b0;
    end
  end

  assign alert_n = ~(trip | bro_alert);
  assign status  = {sd_q, bro_q, fault_q};

endmodule

module pack_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_pin,
  input logic [3:0] ctrl_reg,
  input logic [5:0] status,
  input logic       chg_en,
  input logic       dsg_en,
  input logic       pchg_en,
  input logic       alert_n
);
  a_r5_trip_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    (|status[3:0]) |-> (!chg_en && !dsg_en && !alert_n));
  a_r6_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_reg[0]) && !ctrl_reg[0]) |=> (status[3:0] == 4'b0000));
  a_r7_chg_request: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_reg[2] |-> !chg_en);
  a_r7_dsg_request: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_reg[1] |-> !dsg_en);
  a_r8_pchg_off_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reg[3] |-> !pchg_en);
  a_r9_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_pin |-> (!chg_en && !dsg_en && !pchg_en));
  a_r11_bro_alerts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> !alert_n);
  a_r12_sd_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> (!chg_en && !dsg_en && !pchg_en));
endmodule

bind pack_guard pack_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .ctrl_reg(ctrl_reg),
  .status(status), .chg_en(chg_en), .dsg_en(dsg_en), .pchg_en(pchg_en),
  .alert_n(alert_n)
);

// File: tb/sim_pack_guard.sv
`timescale 1ns/1ps
module sim_pack_guard;
  logic clk = 1'b0, rst_n = 1'b0, tick_in = 1'b0;
  logic oc_chg_flag = 0, ol_dsg_flag = 0, sc_chg_flag = 0, sc_dsg_flag = 0;
  logic bro_flag = 0, sd_flag = 0, ctl_pin = 0, stat_rd = 0;
  logic [3:0] ctrl_reg = 4'b0000, oc_code = 4'd0, ol_code = 4'd0, sc_code = 4'd0;
  logic chg_en, dsg_en, pchg_en, alert_n;
  logic [5:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pack_guard u0 (.*);

  // {ctl_pin, sd_flag, ctrl3, ctrl2, ctrl1, exp chg, exp dsg, exp pchg}
  localparam logic [7:0] VEC [8] = '{
    8'b00000_001, 8'b00010_101, 8'b00001_011, 8'b00111_110,
    8'b10011_000, 8'b10100_000, 8'b01011_000, 8'b00100_000 };

  task automatic clk_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      tick_in = 1'b1; clk_n(1);
      tick_in = 1'b0; clk_n(1);
    end
  endtask

  task automatic clr_pulse();
    ctrl_reg[0] = 1'b1; clk_n(1);
    ctrl_reg[0] = 1'b0; clk_n(1);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clk_n(3);
    rst_n = 1'b1; clk_n(1);
    chk("R1 status", status, 6'h00);
    chk("R1 gates/alert", {chg_en, dsg_en, pchg_en, alert_n}, 4'b0011);

    for (int k = 0; k < 8; k++) begin
      {ctl_pin, sd_flag, ctrl_reg[3:1]} = VEC[k][7:3];
      clk_n(2);
      chk("R7 R8 R9 R12 gate vector", {chg_en, dsg_en, pchg_en}, VEC[k][2:0]);
    end
    ctl_pin = 0; sd_flag = 0; ctrl_reg = 4'b0000; clk_n(2);

    // R2 discharge overload, code 0 -> 33 ticks
    ctrl_reg = 4'b0010; ol_dsg_flag = 1; ol_code = 4'd0; oc_code = 4'd1;
    tick(32);
    chk("R2 before limit", {status, dsg_en}, {6'h00, 1'b1});
    tick(1);
    chk("R2 R5 latched", {status, dsg_en, chg_en, alert_n}, {6'h02, 3'b000});
    ctrl_reg = 4'b0110; clk_n(2);
    chk("R7 ignored while tripped", {chg_en, dsg_en}, 2'b00);
    // R6 clear with fault present, then re-entry after full delay
    clr_pulse();
    chk("R6 cleared", {status, dsg_en, alert_n}, {6'h00, 2'b11});
    tick(32);
    chk("R6 not yet re-entered", status, 6'h00);
    tick(1);
    chk("R6 re-entered", status, 6'h02);
    ol_dsg_flag = 0; clr_pulse();
    chk("R6 cleared after flag drop", {status, alert_n}, {6'h00, 1'b1});

    // R4 restart, charge overcurrent code 1 -> 99 ticks
    ctrl_reg = 4'b0100; oc_chg_flag = 1;
    tick(50);
    oc_chg_flag = 0; clk_n(1); oc_chg_flag = 1;
    tick(98);
    chk("R4 restart no fault", status, 6'h00);
    tick(1);
    chk("R4 R2 fault at 99", {status, chg_en}, {6'h01, 1'b0});
    oc_chg_flag = 0; clr_pulse();

    // R3 short circuit code 0 immediate
    ctrl_reg = 4'b0010; sc_code = 4'd0; sc_dsg_flag = 1; clk_n(1);
    chk("R3 immediate", {status, alert_n}, {6'h08, 1'b0});
    sc_dsg_flag = 0; clr_pulse();
    ctrl_reg = 4'b0100; sc_code = 4'd3; sc_chg_flag = 1;
    tick(5);
    chk("R3 code3 before", status, 6'h00);
    tick(1);
    chk("R3 code3 at 6", status, 6'h04);
    sc_chg_flag = 0; clr_pulse();

    // R10 precharge suspends detection
    ctrl_reg = 4'b0000; oc_code = 4'd0; oc_chg_flag = 1;
    tick(200);
    chk("R10 suspended", {status, alert_n}, {6'h00, 1'b1});
    ctrl_reg = 4'b1000; clk_n(1);
    tick(33);
    chk("R10 counts after precharge off", status, 6'h01);
    oc_chg_flag = 0; clr_pulse(); ctrl_reg = 4'b0000; clk_n(1);

    // R11 brownout
    bro_flag = 1; clk_n(1); bro_flag = 0; clk_n(1);
    chk("R11 set", {status, alert_n}, {6'h10, 1'b0});
    stat_rd = 1; clk_n(1); stat_rd = 0; clk_n(1);
    chk("R11 read releases alert", {status, alert_n}, {6'h10, 1'b1});
    stat_rd = 1; clk_n(1); stat_rd = 0; clk_n(1);
    chk("R11 read alone keeps bit", status, 6'h10);
    clr_pulse();
    chk("R11 pulse alone keeps bit", status, 6'h10);
    stat_rd = 1; clk_n(1); stat_rd = 0; clk_n(1);
    chk("R11 cleared", {status, alert_n}, {6'h00, 1'b1});

    // R12 shutdown
    ctrl_reg = 4'b0110; sd_flag = 1; clk_n(1);
    chk("R12 set", {status, chg_en, dsg_en, pchg_en, alert_n}, {6'h20, 4'b0001});
    sd_flag = 0; clk_n(1);
    chk("R12 released", {status, chg_en, dsg_en, pchg_en}, {6'h00, 3'b111});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule